// File: doc/BRIEF.md
# Floating-Point Compare with Condition-Field Write

This unit evaluates one IEEE-754 ordered relation (greater, less or equal) between two operands and records the outcome as a 4-bit field inside a 32-bit condition register. It runs in three modes: a scalar single-precision compare, a scalar double-precision compare, and a paired compare that treats each 64-bit operand as two independent single-precision lanes. The paired mode condenses both lane results into one field. That field carries each lane's result, plus the OR and the AND of the two.

A compare is launched by pulsing the valid strobe with the operands, mode, relation and destination field index applied. On the next clock edge the selected nibble of the condition register is replaced, and every other nibble keeps its value. On the same edge, an invalid-operation flag records whether a signaling NaN took part in an unordered compare. Between strobes both outputs hold their values.

Top module: `fcmp_cr_unit`

## Requirements
- R1: `kind_i` selects the relation: 2'b00 equal, 2'b01 a greater than b, 2'b10 a less than b, 2'b11 never true. The predicate is true only when the ordered relation holds exactly.
- R2: If any operand taking part in a compare is a NaN (all-ones exponent, nonzero fraction), that compare is unordered and its predicate is false for every relation.
- R3: Positive and negative zero compare equal, and neither is greater or less than the other.
- R4: `inv_o` is set when a compare is unordered and at least one operand is a signaling NaN. A signaling NaN has an all-ones exponent, a nonzero fraction, and a clear top fraction bit. In paired mode either lane can set the flag. Every accepted compare that does not meet this condition clears the flag.
- R5: In the scalar modes the written field is 4'b0100 when the predicate is true and 4'b0000 when it is false.
- R6: In paired mode the written field is {hi, lo, hi|lo, hi&lo}, listed from bit 3 down to bit 0.
- R7: Field index f occupies register bits [(7-f)*4+3 : (7-f)*4]. Only those bits change, and all other register bits are left as they were.
- R8: Scalar single-precision uses bits [31:0] of each operand and ignores bits [63:32]. Double uses all 64 bits. In paired mode, bits [63:32] form the high lane and bits [31:0] form the low lane.
- R9: `mode_i` encoding: 2'b00 scalar single, 2'b01 scalar double, 2'b10 paired single, 2'b11 reserved. A strobe in reserved mode leaves `cr_o` and `inv_o` unchanged.
- R10: `cr_o` and `inv_o` take their new values on the clock edge that samples `vld_i` high. With no strobe, they hold.
- R11: A synchronous active-high reset clears `cr_o` and `inv_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vld_i | input | 1 | Compare strobe |
| mode_i | input | 2 | Precision / lane mode |
| kind_i | input | 2 | Relation select |
| idx_i | input | 3 | Destination field index |
| a_i | input | 64 | Operand A |
| b_i | input | 64 | Operand B |
| cr_o | output | 32 | Condition register |
| inv_o | output | 1 | Invalid-operation flag |

## Verification
All state lives in the condition register and the flag, so a wrong internal value is visible at `cr_o` or `inv_o` one cycle after the strobe that caused it. A faulty field mask or a faulty index mapping corrupts a neighbouring nibble. The bench catches this by comparing the whole register against a running model after every compare, not only the target field. A sign or zero-handling error in the classifier shows up as a wrong field bit on the very next sample. A paired-lane swap appears as bits 3 and 2 of the field trading places.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int FLD_W = 4;

  typedef enum logic [1:0] {
    K_EQ   = 2'b00,
    K_GT   = 2'b01,
    K_LT   = 2'b10,
    K_NONE = 2'b11
  } cmp_kind_e;

  typedef enum logic [1:0] {
    M_SGL  = 2'b00,
    M_DBL  = 2'b01,
    M_PAIR = 2'b10,
    M_RSV  = 2'b11
  } cmp_mode_e;

  typedef struct packed {
    logic gt;
    logic lt;
    logic eq;
    logic unord;
    logic snan;
  } lane_res_t;

  // Pick the predicate for the requested relation (R1)
  function automatic logic pick_pred(lane_res_t r, cmp_kind_e k);
    case (k)
      K_EQ:    return r.eq;
      K_GT:    return r.gt;
      K_LT:    return r.lt;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/fcmp_lane.sv
module fcmp_lane
  import fcmp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] a_i,
  input  logic [EXP_W+FRAC_W:0] b_i,
  output lane_res_t             res_o
);
  localparam int W = 1 + EXP_W + FRAC_W;

  logic             sa, sb;
  logic [W-2:0]     mag_a, mag_b;
  logic             a_nan, b_nan, a_snan, b_snan;
  logic             both_zero, unord;

  assign sa    = a_i[W-1];
  assign sb    = b_i[W-1];
  assign mag_a = a_i[W-2:0];
  assign mag_b = b_i[W-2:0];

  // NaN: exponent all ones with nonzero fraction; signaling when top fraction bit clear
  assign a_nan  = (&a_i[W-2:FRAC_W]) && (|a_i[FRAC_W-1:0]);
  assign b_nan  = (&b_i[W-2:FRAC_W]) && (|b_i[FRAC_W-1:0]);
  assign a_snan = a_nan && !a_i[FRAC_W-1];
  assign b_snan = b_nan && !b_i[FRAC_W-1];

  assign unord     = a_nan || b_nan;
  assign both_zero = (mag_a == '0) && (mag_b == '0);

  always_comb begin
    res_o       = '0;
    res_o.unord = unord;
    res_o.snan  = a_snan || b_snan;
    if (!unord) begin
      res_o.eq = (a_i == b_i) || both_zero;
      if (!both_zero) begin
        if (sa != sb) begin
          res_o.gt = !sa;
          res_o.lt = sa;
        end else if (!sa) begin
          res_o.gt = mag_a > mag_b;
          res_o.lt = mag_a < mag_b;
        end else begin
          res_o.gt = mag_a < mag_b;
          res_o.lt = mag_a > mag_b;
        end
      end
    end
  end
endmodule

// File: rtl/fcmp_field_ins.sv
module fcmp_field_ins
  import fcmp_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int IDX_W = 3
) (
  input  logic [REG_W-1:0] cur_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [FLD_W-1:0] fld_i,
  output logic [REG_W-1:0] nxt_o
);
  localparam int NF = REG_W / FLD_W;

  // Field index counts from the most significant nibble
  for (genvar g = 0; g < NF; g++) begin : g_fld
    assign nxt_o[g*FLD_W +: FLD_W] =
      (idx_i == IDX_W'(NF - 1 - g)) ? fld_i : cur_i[g*FLD_W +: FLD_W];
  end
endmodule

// File: rtl/fcmp_cr_unit.sv
module fcmp_cr_unit
  import fcmp_pkg::*;
#(
  parameter int REG_W    = 32,
  parameter int S_EXP_W  = 8,
  parameter int S_FRAC_W = 23,
  parameter int D_EXP_W  = 11,
  parameter int D_FRAC_W = 52,
  localparam int S_W     = 1 + S_EXP_W + S_FRAC_W,
  localparam int OP_W    = 2 * S_W,
  localparam int IDX_W   = $clog2(REG_W / FLD_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld_i,
  input  logic [1:0]       mode_i,
  input  logic [1:0]       kind_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [OP_W-1:0]  a_i,
  input  logic [OP_W-1:0]  b_i,
  output logic [REG_W-1:0] cr_o,
  output logic             inv_o
);
  cmp_kind_e  kind;
  cmp_mode_e  mode;
  lane_res_t  s_res [2];
  lane_res_t  d_res;
  logic       p_lo, p_hi, p_d;
  logic [FLD_W-1:0] fld;
  logic       inv_n, upd;
  logic [REG_W-1:0] cr_q, cr_nxt;
  logic       inv_q;

  assign kind = cmp_kind_e'(kind_i);
  assign mode = cmp_mode_e'(mode_i);

  // Two single-precision lanes: lane 0 also serves the scalar single mode
  for (genvar ln = 0; ln < 2; ln++) begin : g_sl
    fcmp_lane #(.EXP_W(S_EXP_W), .FRAC_W(S_FRAC_W)) u_sl (
      .a_i  (a_i[ln*S_W +: S_W]),
      .b_i  (b_i[ln*S_W +: S_W]),
      .res_o(s_res[ln])
    );
  end

  fcmp_lane #(.EXP_W(D_EXP_W), .FRAC_W(D_FRAC_W)) u_dl (
    .a_i  (a_i),
    .b_i  (b_i),
    .res_o(d_res)
  );

  assign p_lo = pick_pred(s_res[0], kind);
  assign p_hi = pick_pred(s_res[1], kind);
  assign p_d  = pick_pred(d_res, kind);

  always_comb begin
    fld   = '0;
    inv_n = 1'b0;
    upd   = 1'b1;
    case (mode)
      M_SGL: begin
        fld   = {1'b0, p_lo, 2'b00};
        inv_n = s_res[0].unord && s_res[0].snan;
      end
      M_DBL: begin
        fld   = {1'b0, p_d, 2'b00};
        inv_n = d_res.unord && d_res.snan;
      end
      M_PAIR: begin
        fld   = {p_hi, p_lo, p_hi | p_lo, p_hi & p_lo};
        inv_n = (s_res[0].unord && s_res[0].snan) ||
                (s_res[1].unord && s_res[1].snan);
      end
      default: upd = 1'b0;
    endcase
  end

  fcmp_field_ins #(.REG_W(REG_W), .IDX_W(IDX_W)) u_ins (
    .cur_i(cr_q),
    .idx_i(idx_i),
    .fld_i(fld),
    .nxt_o(cr_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cr_q  <= '0;
      inv_q <= 1'b0;
    end else if (vld_i && upd) begin
      cr_q  <= cr_nxt;
      inv_q <= inv_n;
    end
  end

  assign cr_o  = cr_q;
  assign inv_o = inv_q;
endmodule

// File: rtl/fcmp_cr_chk.sv
module fcmp_cr_chk #(
  parameter int REG_W = 32,
  localparam int NF    = REG_W / 4,
  localparam int IDX_W = $clog2(NF)
) (
  input logic             clk,
  input logic             rst,
  input logic             vld_i,
  input logic [1:0]       mode_i,
  input logic [IDX_W-1:0] idx_i,
  input logic [REG_W-1:0] cr_o,
  input logic             inv_o
);
  logic [IDX_W-1:0] idx_q;
  logic [REG_W-1:0] keep_mask;
  logic [3:0]       fld_seen;

  always_ff @(posedge clk) idx_q <= idx_i;

  always_comb begin
    keep_mask = ~({{(REG_W-4){1'b0}}, 4'hF} << ((NF - 1 - int'(idx_i)) * 4));
    fld_seen  = 4'(cr_o >> ((NF - 1 - int'(idx_q)) * 4));
  end

  // R10
  hold_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !vld_i |=> ($stable(cr_o) && $stable(inv_o)));

  // R7
  other_fields_kept_chk: assert property (@(posedge clk) disable iff (rst)
    vld_i |=> (((cr_o ^ $past(cr_o)) & $past(keep_mask)) == '0));

  // R6
  pair_field_shape_chk: assert property (@(posedge clk) disable iff (rst)
    (vld_i && mode_i == 2'b10) |=>
      (fld_seen[1] == (fld_seen[3] | fld_seen[2]) &&
       fld_seen[0] == (fld_seen[3] & fld_seen[2])));

  // R5
  scalar_field_shape_chk: assert property (@(posedge clk) disable iff (rst)
    (vld_i && (mode_i == 2'b00 || mode_i == 2'b01)) |=>
      (fld_seen[3] == 1'b0 && fld_seen[1:0] == 2'b00));

  // R9
  reserved_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (vld_i && mode_i == 2'b11) |=> ($stable(cr_o) && $stable(inv_o)));

  // R11
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (cr_o == '0 && inv_o == 1'b0));
endmodule

bind fcmp_cr_unit fcmp_cr_chk #(.REG_W(REG_W)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .vld_i (vld_i),
  .mode_i(mode_i),
  .idx_i (idx_i),
  .cr_o  (cr_o),
  .inv_o (inv_o)
);

// File: tb/tb_fcmp_cr_unit.sv
`timescale 1ns/1ps
module tb_fcmp_cr_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        vld;
  logic [1:0]  mode, kind;
  logic [2:0]  idx;
  logic [63:0] a, b;
  logic [31:0] cr;
  logic        inv;

  int errs = 0;
  int checks = 0;
  bit done = 0;
  logic [31:0] model = '0;

  always #2.5 clk = ~clk;

  fcmp_cr_unit dut (
    .clk(clk), .rst(rst), .vld_i(vld), .mode_i(mode), .kind_i(kind),
    .idx_i(idx), .a_i(a), .b_i(b), .cr_o(cr), .inv_o(inv)
  );

  typedef struct packed {
    logic [1:0]  m;
    logic [1:0]  k;
    logic [2:0]  f;
    logic [63:0] a;
    logic [63:0] b;
    logic [3:0]  fld;
    logic        inv;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd2, 3'd0, 64'hFFFFFFFF_3F800000, 64'h00000000_40000000, 4'h4, 1'b0}, // R1 R8 lt
    '{2'd0, 2'd0, 3'd7, 64'h0,                 64'h00000000_80000000, 4'h4, 1'b0}, // R3 eq
    '{2'd0, 2'd1, 3'd3, 64'h00000000_40000000, 64'h00000000_3F800000, 4'h4, 1'b0}, // R1 gt
    '{2'd0, 2'd1, 3'd3, 64'h0,                 64'h00000000_80000000, 4'h0, 1'b0}, // R3 gt
    '{2'd0, 2'd1, 3'd2, 64'h00000000_BF800000, 64'h00000000_C0000000, 4'h4, 1'b0}, // R1 neg
    '{2'd0, 2'd2, 3'd2, 64'h00000000_7FC00000, 64'h00000000_3F800000, 4'h0, 1'b0}, // R2 qnan
    '{2'd0, 2'd0, 3'd4, 64'h00000000_7F800001, 64'h00000000_7F800001, 4'h0, 1'b1}, // R4 snan
    '{2'd0, 2'd0, 3'd4, 64'h00000000_7F800000, 64'h00000000_7F800000, 4'h4, 1'b0}, // R4 inf
    '{2'd1, 2'd1, 3'd5, 64'h40000000_00000000, 64'h3FF00000_00000000, 4'h4, 1'b0}, // R8 dbl
    '{2'd1, 2'd2, 3'd6, 64'hBFF00000_00000000, 64'h3FF00000_00000000, 4'h4, 1'b0}, // R1 dbl
    '{2'd1, 2'd0, 3'd6, 64'h3FF00000_00000001, 64'h3FF00000_00000000, 4'h0, 1'b0}, // R8 dbl
    '{2'd1, 2'd2, 3'd0, 64'h7FF00000_00000001, 64'h0,                 4'h0, 1'b1}, // R4 dbl
    '{2'd1, 2'd0, 3'd0, 64'h7FF80000_00000000, 64'h7FF80000_00000000, 4'h0, 1'b0}, // R2 dbl
    '{2'd2, 2'd1, 3'd1, 64'h40000000_3F800000, 64'h3F800000_40000000, 4'hA, 1'b0}, // R6
    '{2'd2, 2'd0, 3'd2, 64'h3F800000_00000000, 64'h3F800000_80000000, 4'hF, 1'b0}, // R6 R3
    '{2'd2, 2'd2, 3'd7, 64'h40000000_3F800000, 64'h3F800000_40000000, 4'h6, 1'b0}, // R6 R8
    '{2'd2, 2'd0, 3'd3, 64'h3F800000_7F800001, 64'h3F800000_3F800000, 4'hA, 1'b1}, // R4 pair
    '{2'd0, 2'd3, 3'd1, 64'h00000000_3F800000, 64'h00000000_3F800000, 4'h0, 1'b0}, // R1 none
    '{2'd0, 2'd0, 3'd6, 64'h7F800001_3F800000, 64'h00000000_3F800000, 4'h4, 1'b0}  // R8 upper
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic [1:0] m, logic [1:0] k, logic [2:0] f,
                       logic [63:0] va, logic [63:0] vb);
    @(negedge clk);
    mode = m; kind = k; idx = f; a = va; b = vb; vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
  endtask

  function automatic logic [31:0] ins(logic [31:0] r, logic [2:0] f, logic [3:0] v);
    int sh = (7 - int'(f)) * 4;
    return (r & ~(32'hF << sh)) | (32'(v) << sh);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; vld = 1'b0; mode = '0; kind = '0; idx = '0; a = '0; b = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    check("R11 cr", cr, 32'h0);
    check("R11 inv", {31'b0, inv}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].m, VECS[i].k, VECS[i].f, VECS[i].a, VECS[i].b);
      model = ins(model, VECS[i].f, VECS[i].fld);
      check($sformatf("R7 R5 R6 vec%0d cr", i), cr, model);
      check($sformatf("R4 vec%0d inv", i), {31'b0, inv}, {31'b0, VECS[i].inv});
    end

    // R10: inputs change without strobe, outputs hold
    @(negedge clk);
    mode = 2'd0; kind = 2'd0; idx = 3'd5; a = 64'h7F800001; b = 64'h7F800001;
    repeat (3) @(negedge clk);
    check("R10 hold cr", cr, model);
    check("R10 hold inv", {31'b0, inv}, 32'h0);

    // R9: set flag, then reserved mode strobe leaves cr and flag alone
    apply(2'd0, 2'd0, 3'd5, 64'h7F800001, 64'h7F800001);
    model = ins(model, 3'd5, 4'h0);
    check("R4 set cr", cr, model);
    check("R4 set inv", {31'b0, inv}, 32'h1);
    apply(2'd3, 2'd0, 3'd5, 64'h3F800000, 64'h3F800000);
    check("R9 rsv cr", cr, model);
    check("R9 rsv inv", {31'b0, inv}, 32'h1);

    // R10: update seen exactly one edge after the strobe
    @(negedge clk);
    mode = 2'd0; kind = 2'd0; idx = 3'd5; a = 64'h3F800000; b = 64'h3F800000; vld = 1'b1;
    check("R10 before edge", cr, model);
    @(negedge clk);
    vld = 1'b0;
    model = ins(model, 3'd5, 4'h4);
    check("R10 after edge", cr, model);

    // R11: mid-run reset
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R11 rerst cr", cr, 32'h0);
    check("R11 rerst inv", {31'b0, inv}, 32'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule